// File: doc/BRIEF.md
# SPI Master with Slave-Select Management

This block is a serial peripheral interface master for 8-bit frames. Each frame goes out most significant bit first. The clock idles low, new data is presented on the first (rising) edge of each bit, and the input line is sampled on the second (falling) edge. The serial clock rate is set by a divider: a 3-bit exponent in the control register makes each half period of the serial clock last 2^n system clocks. Software starts a frame by writing the data register. A busy flag then covers the whole frame. When the frame ends, the received byte is held in a readable register and a receive-ready flag is set.

The slave-select line works in one of three ways, chosen by two control bits.

- **Software level:** the external pin is ignored and the internal select level comes from a control bit.
- **Hardware output:** the pin is driven low for as long as the block is enabled. It does not toggle between frames. It is driven high when the block is disabled.
- **Input:** the pin driver is released, so several masters can share the bus. A low level on the pin while this block is an enabled master means another master has taken the bus. The block then raises a sticky mode fault, drops its enable and master bits, aborts any frame and releases the clock and data outputs.

Register map (2-bit address): 0 = control, 1 = data (a write sends a frame, a read returns the last received byte), 2 = status.

Top module: `spi_nss_master`

## Requirements
- R1: After reset, the control and status registers read 0, and sck, sckOe, mosiOe and nssOe are all 0.
- R2: A frame moves 8 bits MSB first. mosi changes only when sck rises, miso is sampled when sck falls, and sck is low whenever busy is low. The received byte reads back from address 1.
- R3: Control bits [7:5] hold a value d. Each sck half period then lasts 2^d system clocks; d=1 divides the system clock by 4. A frame keeps busy high for 16·2^d cycles.
- R4: Writing address 1 while control bit0 (enable) and bit1 (master) are set and busy is low starts a frame. busy (status bit0) is high from the cycle after the write until the eighth falling sck edge. A write to address 1 while busy, or while not an enabled master, is ignored.
- R5: With control bit2 (software select) set, the internal select level is control bit3, nssIn is ignored and nssOe is 0.
- R6: With control bit4 (drive select) set and bit2 clear, nssOe is 1 and nssOut equals the inverse of the enable bit. nssOut stays low through frames, and a low nssIn raises no fault in this mode.
- R7: With control bits 2 and 4 clear, nssOe is 0. A low nssIn while the block is an enabled master sets the fault flag (status bit2) and clears control bits 0 and 1. It also ends any frame without setting receive-ready and drops sckOe and mosiOe.
- R8: The fault flag stays set until a 1 is written to status bit2. While it is set, writes to the enable bit are ignored; the other control bits are still written.
- R9: In software select mode, a select level of 0 while the block is an enabled master raises the same fault as R7.
- R10: When a frame completes, status bit1 (receive-ready) is set. Writing a 1 to status bit1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for the current address |
| busy | output | 1 | Frame in progress |
| sck | output | 1 | Serial clock |
| sckOe | output | 1 | Serial clock driver enable |
| mosi | output | 1 | Serial data out |
| mosiOe | output | 1 | Serial data driver enable |
| miso | input | 1 | Serial data in |
| nssIn | input | 1 | Slave-select pin level seen from outside |
| nssOut | output | 1 | Slave-select pin drive value |
| nssOe | output | 1 | Slave-select pin driver enable (0 = high impedance) |

## Verification
A mode fault and frame completion can occur in the same clock: the other master can pull the select pin low on the cycle of the eighth falling sck edge. The bench counts clocks from the data write at the fastest divider and drops nssIn so that the fault lands exactly on that edge. It then expects the fault set, busy clear and receive-ready still clear. A second run drops nssIn one cycle later and expects both receive-ready and the fault, with the received byte intact.

// File: rtl/spi_nss_pkg.sv
package spi_nss_pkg;

  // Register addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // Control register bit positions
  localparam int CTL_EN     = 0;
  localparam int CTL_MASTER = 1;
  localparam int CTL_SWSEL  = 2;
  localparam int CTL_SWLVL  = 3;
  localparam int CTL_DRIVE  = 4;
  localparam int CTL_DIV    = 5;

  // Status register bit positions
  localparam int STA_BUSY  = 0;
  localparam int STA_RXRDY = 1;
  localparam int STA_FAULT = 2;

  typedef enum logic {ST_IDLE, ST_SHIFT} xferState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadTx;
    logic riseEdge;
    logic fallEdge;
    logic finish;
  } dpStrobe_t;

endpackage

// File: rtl/spi_nss_ctrl.sv
module spi_nss_ctrl
  import spi_nss_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [FRAME_W-1:0] regWrData,
  input  logic               nssIn,
  output dpStrobe_t          strobe,
  output logic [FRAME_W-1:0] ctrlRd,
  output logic [FRAME_W-1:0] statRd,
  output logic               busy,
  output logic               modeFault,
  output logic               sck,
  output logic               drvOe,
  output logic               nssOut,
  output logic               nssOe
);

  localparam int CNT_W = (1 << DIV_W) - 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  logic             enBit, masterBit, swSel, swLevel, nssDrive;
  logic [DIV_W-1:0] divSel;
  logic             faultFlag, rxRdy, sckLvl;
  xferState_e       state;
  logic [CNT_W-1:0] divCnt, halfLoad;
  logic [BIT_W-1:0] bitCnt;

  logic ctrlWr, dataWr, statWr, run, faultCond, tick, accept;

  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);
  assign dataWr = regWrEn && (regAddr == ADDR_DATA);
  assign statWr = regWrEn && (regAddr == ADDR_STAT);
  assign run    = enBit && masterBit;

  // Internal select low while acting as master means a competing master
  assign faultCond = run && (swSel ? !swLevel : (!nssDrive && !nssIn));

  always_comb begin
    logic [CNT_W:0] one;
    one      = (CNT_W+1)'(1);
    halfLoad = CNT_W'((one << divSel) - (CNT_W+1)'(1));
  end

  assign tick   = (state == ST_SHIFT) && (divCnt == '0);
  assign accept = dataWr && run && (state == ST_IDLE) && !faultCond;

  always_comb begin
    strobe.loadTx   = accept;
    strobe.riseEdge = tick && !sckLvl && !faultCond;
    strobe.fallEdge = tick && sckLvl && !faultCond;
    strobe.finish   = tick && sckLvl && !faultCond && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit     <= 1'b0;
      masterBit <= 1'b0;
      swSel     <= 1'b0;
      swLevel   <= 1'b0;
      nssDrive  <= 1'b0;
      divSel    <= '0;
      faultFlag <= 1'b0;
      rxRdy     <= 1'b0;
      sckLvl    <= 1'b0;
      state     <= ST_IDLE;
      divCnt    <= '0;
      bitCnt    <= '0;
    end else if (faultCond) begin
      faultFlag <= 1'b1;
      enBit     <= 1'b0;
      masterBit <= 1'b0;
      state     <= ST_IDLE;
      sckLvl    <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enBit     <= regWrData[CTL_EN] && !faultFlag;
        masterBit <= regWrData[CTL_MASTER];
        swSel     <= regWrData[CTL_SWSEL];
        swLevel   <= regWrData[CTL_SWLVL];
        nssDrive  <= regWrData[CTL_DRIVE];
        divSel    <= regWrData[CTL_DIV +: DIV_W];
      end
      if (statWr) begin
        if (regWrData[STA_FAULT]) faultFlag <= 1'b0;
        if (regWrData[STA_RXRDY]) rxRdy     <= 1'b0;
      end
      if (!run) begin
        state  <= ST_IDLE;
        sckLvl <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (accept) begin
              state  <= ST_SHIFT;
              divCnt <= halfLoad;
              bitCnt <= '0;
              sckLvl <= 1'b0;
            end
          end
          ST_SHIFT: begin
            if (tick) begin
              divCnt <= halfLoad;
              sckLvl <= !sckLvl;
              if (sckLvl) begin
                bitCnt <= bitCnt + 1'b1;
                if (bitCnt == LAST_BIT) begin
                  state <= ST_IDLE;
                  rxRdy <= 1'b1;
                end
              end
            end else begin
              divCnt <= divCnt - 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    ctrlRd                      = '0;
    ctrlRd[CTL_EN]              = enBit;
    ctrlRd[CTL_MASTER]          = masterBit;
    ctrlRd[CTL_SWSEL]           = swSel;
    ctrlRd[CTL_SWLVL]           = swLevel;
    ctrlRd[CTL_DRIVE]           = nssDrive;
    ctrlRd[CTL_DIV +: DIV_W]    = divSel;
    statRd                      = '0;
    statRd[STA_BUSY]            = (state == ST_SHIFT);
    statRd[STA_RXRDY]           = rxRdy;
    statRd[STA_FAULT]           = faultFlag;
  end

  assign busy      = (state == ST_SHIFT);
  assign modeFault = faultFlag;
  assign sck       = sckLvl;
  assign drvOe     = run;
  assign nssOe     = !swSel && nssDrive;
  assign nssOut    = !enBit;

endmodule

// File: rtl/spi_nss_datapath.sv
module spi_nss_datapath
  import spi_nss_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [FRAME_W-1:0] txData,
  input  logic               miso,
  output logic               mosi,
  output logic [FRAME_W-1:0] rxData
);

  logic [FRAME_W-1:0] txShift;
  logic [FRAME_W-2:0] rxShift;
  logic               mosiReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
      mosiReg <= 1'b0;
    end else begin
      if (strobe.loadTx) begin
        txShift <= txData;
        rxShift <= '0;
      end
      // Mode 1: present data on the leading edge
      if (strobe.riseEdge) mosiReg <= txShift[FRAME_W-1];
      // Sample on the trailing edge
      if (strobe.fallEdge) begin
        rxShift <= {rxShift[FRAME_W-3:0], miso};
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
      end
      if (strobe.finish) rxData <= {rxShift, miso};
    end
  end

  assign mosi = mosiReg;

endmodule

// File: rtl/spi_nss_master.sv
module spi_nss_master
  import spi_nss_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [FRAME_W-1:0] regWrData,
  output logic [FRAME_W-1:0] regRdData,
  output logic               busy,
  output logic               sck,
  output logic               sckOe,
  output logic               mosi,
  output logic               mosiOe,
  input  logic               miso,
  input  logic               nssIn,
  output logic               nssOut,
  output logic               nssOe
);

  dpStrobe_t          strobe;
  logic [FRAME_W-1:0] ctrlRd, statRd, rxData;
  logic               modeFault, drvOe;

  spi_nss_ctrl #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .nssIn(nssIn), .strobe(strobe),
    .ctrlRd(ctrlRd), .statRd(statRd), .busy(busy), .modeFault(modeFault),
    .sck(sck), .drvOe(drvOe), .nssOut(nssOut), .nssOe(nssOe)
  );

  spi_nss_datapath #(.FRAME_W(FRAME_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(regWrData),
    .miso(miso), .mosi(mosi), .rxData(rxData)
  );

  assign sckOe  = drvOe;
  assign mosiOe = drvOe;

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = ctrlRd;
      ADDR_DATA: regRdData = rxData;
      ADDR_STAT: regRdData = statRd;
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/spi_nss_checker.sv
module spi_nss_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic sck,
  input logic sckOe,
  input logic mosi,
  input logic nssOut,
  input logic nssOe,
  input logic modeFault
);

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);

  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

  assert_busy_master_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> sckOe);

  assert_nss_steady_R6: assert property (@(posedge clk) disable iff (!rstN)
    (nssOe && busy) |-> !nssOut);

  assert_fault_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |-> (!sckOe && !busy));

endmodule

bind spi_nss_master spi_nss_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .sck(sck), .sckOe(sckOe),
  .mosi(mosi), .nssOut(nssOut), .nssOe(nssOe), .modeFault(modeFault)
);

// File: tb/sim_spi_nss_master.sv
`timescale 1ns/1ps
module sim_spi_nss_master;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       busy, sck, sckOe, mosi, mosiOe, nssOut, nssOe;
  logic       miso = 1'b0;
  logic       nssIn = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spi_nss_master u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy), .sck(sck),
    .sckOe(sckOe), .mosi(mosi), .mosiOe(mosiOe), .miso(miso),
    .nssIn(nssIn), .nssOut(nssOut), .nssOe(nssOe)
  );

  // Behavioural mode-1 slave
  logic [7:0] slvByte = 8'd0;
  logic [7:0] slvCap = 8'd0;
  int         riseIdx = 0;

  always @(posedge sck or negedge busy) begin
    if (!busy) riseIdx <= 0;
    else begin
      miso    <= slvByte[3'(7 - riseIdx)];
      riseIdx <= riseIdx + 1;
    end
  end

  always @(negedge sck) slvCap <= {slvCap[6:0], mosi};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard: expected mosi frames
  logic [7:0] expQ[$];
  logic       prevSck = 1'b0, prevBusy = 1'b0;
  int         fallCnt = 0;

  always @(negedge clk) begin
    if (prevSck && !sck) fallCnt++;
    if (!prevBusy && busy) fallCnt = 0;
    if (prevBusy && !busy && expQ.size() > 0) begin
      logic [7:0] item;
      item = expQ.pop_front();
      if (fallCnt == 8) chk("R2 mosi frame MSB first", slvCap, item);
    end
    prevSck  = sck;
    prevBusy = busy;
  end

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] rx, input int half);
    int busyCnt = 0;
    int hiCnt = 0;
    logic [7:0] v;
    slvByte = rx;
    expQ.push_back(tx);
    wrReg(2'd1, tx);
    while (busy && busyCnt < 5000) begin
      busyCnt++;
      if (sck) hiCnt++;
      @(negedge clk);
    end
    chk("R3/R4 busy length", busyCnt, 16 * half);
    chk("R3 sck high time", hiCnt, 8 * half);
    rdReg(2'd1, v);
    chk("R2 received byte", v, rx);
    rdReg(2'd2, v);
    chk("R10 rxReady set", v[1], 1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdReg(2'd0, v); chk("R1 ctrl reset", v, 0);
    rdReg(2'd2, v); chk("R1 status reset", v, 0);
    chk("R1 sck idle", sck, 0);
    chk("R1 driver enables", {sckOe, mosiOe, nssOe}, 0);

    // R5 software select, level high, external pin low ignored
    nssIn = 1'b0;
    wrReg(2'd0, 8'h0F);
    rdReg(2'd2, v); chk("R5 pin ignored no fault", v[2], 0);
    chk("R5 pin released", nssOe, 0);
    xfer(8'hA5, 8'h3C, 1);
    wrReg(2'd2, 8'h02);
    rdReg(2'd2, v); chk("R10 rxReady cleared", v[1], 0);
    xfer(8'h01, 8'h80, 1);
    xfer(8'hFF, 8'h00, 1);

    // R4 write while busy ignored
    slvByte = 8'h5A;
    expQ.push_back(8'hC3);
    wrReg(2'd1, 8'hC3);
    repeat (3) @(negedge clk);
    wrReg(2'd1, 8'h77);
    while (busy) @(negedge clk);
    rdReg(2'd1, v); chk("R4 busy write ignored rx", v, 8'h5A);

    // R3 divider settings
    wrReg(2'd0, 8'h2F);
    xfer(8'h69, 8'h96, 2);
    wrReg(2'd0, 8'h4F);
    xfer(8'h3E, 8'hE3, 4);

    // R4 not master: data write ignored
    wrReg(2'd0, 8'h0D);
    wrReg(2'd1, 8'h12);
    chk("R4 no start without master", busy, 0);
    @(negedge clk);
    chk("R4 sck quiet", sck, 0);

    // R9 software level low raises fault
    wrReg(2'd0, 8'h07);
    @(negedge clk);
    rdReg(2'd2, v); chk("R9 fault set", v[2], 1);
    rdReg(2'd0, v); chk("R9 enable/master cleared", v, 8'h04);
    chk("R7 drivers released", {sckOe, mosiOe}, 0);

    // R8 sticky fault blocks enable
    wrReg(2'd0, 8'h0F);
    rdReg(2'd0, v); chk("R8 enable blocked", v, 8'h0E);
    rdReg(2'd2, v); chk("R8 fault sticky", v[2], 1);
    wrReg(2'd2, 8'h04);
    rdReg(2'd2, v); chk("R8 fault cleared", v[2], 0);
    wrReg(2'd0, 8'h0F);
    rdReg(2'd0, v); chk("R8 enable after clear", v, 8'h0F);

    // R6 hardware output select
    nssIn = 1'b0;
    wrReg(2'd0, 8'h13);
    chk("R6 pin driven", nssOe, 1);
    chk("R6 pin low when enabled", nssOut, 0);
    xfer(8'hB2, 8'h4D, 1);
    chk("R6 pin still low", nssOut, 0);
    rdReg(2'd2, v); chk("R6 no fault on low pin", v[2], 0);
    wrReg(2'd0, 8'h12);
    chk("R6 pin high when disabled", nssOut, 1);

    // R7 input mode fault mid-frame
    nssIn = 1'b1;
    wrReg(2'd2, 8'h06);
    wrReg(2'd0, 8'h03);
    chk("R7 pin released", nssOe, 0);
    slvByte = 8'hAA;
    expQ.push_back(8'h55);
    wrReg(2'd1, 8'h55);
    repeat (5) @(negedge clk);
    nssIn = 1'b0;
    @(negedge clk);
    rdReg(2'd2, v); chk("R7 fault aborts frame", v, 8'h04);
    rdReg(2'd0, v); chk("R7 enable/master cleared", v, 8'h00);
    chk("R7 drivers released", {sckOe, mosiOe}, 0);

    // Fault on the final falling edge: fault wins
    nssIn = 1'b1;
    wrReg(2'd2, 8'h06);
    wrReg(2'd0, 8'h03);
    slvByte = 8'h81;
    expQ.push_back(8'h7E);
    wrReg(2'd1, 8'h7E);
    repeat (15) @(negedge clk);
    nssIn = 1'b0;
    @(negedge clk);
    rdReg(2'd2, v); chk("R7 fault on last edge, no rxReady", v, 8'h04);

    // Fault one cycle after completion: both flags
    nssIn = 1'b1;
    wrReg(2'd2, 8'h06);
    wrReg(2'd0, 8'h03);
    slvByte = 8'h24;
    expQ.push_back(8'hDB);
    wrReg(2'd1, 8'hDB);
    repeat (16) @(negedge clk);
    nssIn = 1'b0;
    @(negedge clk);
    rdReg(2'd2, v); chk("R10 completion then fault", v, 8'h06);
    rdReg(2'd1, v); chk("R2 byte kept after fault", v, 8'h24);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule